// File: doc/BRIEF.md
# Nibble-Parallel CRC-5 Generator

This block computes a five-bit cyclic redundancy check with generator x^5 + x^2 + 1 and takes in four message bits on every clock on which its strobe is high. It applies the direct form of the shift-register recurrence, where the message bit is combined with the register's top bit before the feedback is applied. The register therefore holds the finished check value of everything taken in so far. No trailing zero bits are ever fed to flush it.

A client first loads a seed, either all ones (the usual value for short token packets) or all zeros (handy for bring-up and testing), with the synchronous reset or the synchronous init input. It then presents nibbles with the strobe high, the earliest message bit on the nibble's top bit. The check value of the message taken in so far is on the output one cycle after each accepted nibble.

Top module: `crc5_nibble_engine`

## Requirements
- R1: One accepted nibble gives the same register value as four serial steps applied in turn to nib_i[3], nib_i[2], nib_i[1] and then nib_i[0]. The serial step on bit d maps c to n, where n[0]=c[4]^d, n[1]=c[0], n[2]=c[1]^c[4]^d, n[3]=c[2] and n[4]=c[3].
- R2: With rst_i high at a clock edge, the register takes the seed after that edge: 5'b11111 when seed_ones_i is 1 and 5'b00000 when it is 0.
- R3: Known values: from seed 00000, nibble 1010 gives 00111 and nibble 1000 gives 01101. From seed 11111, nibble 1010 gives 00001 and nibble 0000 gives 00110.
- R4: With init_i high at a clock edge, the register takes the selected seed as in R2, even when vld_i is also high.
- R5: With vld_i low and rst_i and init_i low, the register keeps its value and nib_i is ignored.
- R6: The value after the last nibble of a message equals the serial CRC of that message's bits alone, with no appended zeros. This holds for a two-nibble message.
- R7: The result of a nibble accepted at one edge appears after that edge, and nibbles may be accepted on every cycle back to back.
- R8: An all-zero register that takes in an all-zero nibble stays all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high, loads the seed |
| init_i | input | 1 | Synchronous seed load, takes priority over vld_i |
| seed_ones_i | input | 1 | Seed select: 1 selects all ones, 0 selects all zeros |
| vld_i | input | 1 | Nibble strobe |
| nib_i | input | 4 | Message nibble, bit 3 is the earliest bit |
| crc_o | output | 5 | Current check register |

## Verification
Every result of this block is due exactly one edge after the stimulus that causes it. A seed load appears one cycle after rst_i or init_i is sampled. A nibble's contribution appears one cycle after the edge that samples vld_i. A held value is unchanged at each edge where vld_i is low. The bench changes its inputs on the falling edge and reads crc_o one time unit after the following rising edge, so each read sees the edge it checks and nothing later. The bit-serial model in the bench is advanced only for nibbles the design accepted, so its value lines up with the register on every cycle of a back-to-back stream.

// File: rtl/crc5_pkg.sv
package crc5_pkg;
  localparam int CRC_W = 5;
  localparam int NIB_W = 4;

  typedef logic [CRC_W-1:0] crc_t;
  typedef logic [NIB_W-1:0] nib_t;

  // register bits that receive the feedback term (x^2 and x^0)
  localparam crc_t FB_TAPS = 5'b00101;

  // one direct-form step: message bit enters at the top, feedback to all taps
  function automatic crc_t crc_bit_step(crc_t c, logic d);
    logic fb;
    fb = c[CRC_W-1] ^ d;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? FB_TAPS : '0);
  endfunction

  // four steps unrolled, earliest bit is the nibble's top bit
  function automatic crc_t crc_nib_chain(crc_t c, nib_t d);
    crc_t r;
    r = c;
    for (int i = NIB_W - 1; i >= 0; i--) r = crc_bit_step(r, d[i]);
    return r;
  endfunction

  // the same transform collapsed into one XOR level per output bit
  function automatic crc_t crc_nib_flat(crc_t c, nib_t d);
    crc_t n;
    n[0] = c[1] ^ c[4] ^ d[0] ^ d[3];
    n[1] = c[2] ^ d[1];
    n[2] = c[1] ^ c[3] ^ c[4] ^ d[0] ^ d[2] ^ d[3];
    n[3] = c[2] ^ c[4] ^ d[1] ^ d[3];
    n[4] = c[0] ^ c[3] ^ d[2];
    return n;
  endfunction

  function automatic crc_t seed_value(logic ones);
    return ones ? '1 : '0;
  endfunction
endpackage

// File: rtl/crc5_next.sv
module crc5_next
  import crc5_pkg::*;
#(
  parameter bit FLAT_EQ = 1'b1
) (
  input  crc_t cur_i,
  input  nib_t nib_i,
  output crc_t nxt_o
);
  generate
    if (FLAT_EQ) begin : g_flat
      always_comb nxt_o = crc_nib_flat(cur_i, nib_i);
    end else begin : g_chain
      crc_t stage [NIB_W+1];
      assign stage[0] = cur_i;
      for (genvar k = 0; k < NIB_W; k++) begin : g_step
        assign stage[k+1] = crc_bit_step(stage[k], nib_i[NIB_W-1-k]);
      end
      assign nxt_o = stage[NIB_W];
    end
  endgenerate
endmodule

// File: rtl/crc5_seed_sel.sv
module crc5_seed_sel
  import crc5_pkg::*;
(
  input  logic rst_i,
  input  logic init_i,
  input  logic seed_ones_i,
  input  logic vld_i,
  output logic load_o,
  output logic upd_o,
  output crc_t seed_o
);
  always_comb begin
    load_o = rst_i | init_i;
    upd_o  = vld_i & ~load_o;
    seed_o = seed_value(seed_ones_i);
  end
endmodule

// File: rtl/crc5_state.sv
module crc5_state
  import crc5_pkg::*;
(
  input  logic clk_i,
  input  logic load_i,
  input  logic upd_i,
  input  crc_t seed_i,
  input  crc_t nxt_i,
  output crc_t q_o
);
  always_ff @(posedge clk_i) begin
    if (load_i)     q_o <= seed_i;
    else if (upd_i) q_o <= nxt_i;
  end
endmodule

// File: rtl/crc5_nibble_engine.sv
module crc5_nibble_engine
  import crc5_pkg::*;
#(
  parameter bit FLAT_EQ = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             init_i,
  input  logic             seed_ones_i,
  input  logic             vld_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic [CRC_W-1:0] crc_o
);
  // named internal events, visible to the bound checker
  logic seed_load;
  logic upd_en;
  crc_t seed_val;
  crc_t nxt_crc;
  crc_t crc_q;

  crc5_seed_sel u_sel (
    .rst_i       (rst_i),
    .init_i      (init_i),
    .seed_ones_i (seed_ones_i),
    .vld_i       (vld_i),
    .load_o      (seed_load),
    .upd_o       (upd_en),
    .seed_o      (seed_val)
  );

  crc5_next #(.FLAT_EQ(FLAT_EQ)) u_next (
    .cur_i (crc_q),
    .nib_i (nib_i),
    .nxt_o (nxt_crc)
  );

  crc5_state u_state (
    .clk_i  (clk_i),
    .load_i (seed_load),
    .upd_i  (upd_en),
    .seed_i (seed_val),
    .nxt_i  (nxt_crc),
    .q_o    (crc_q)
  );

  assign crc_o = crc_q;
endmodule

// File: rtl/crc5_nibble_chk.sv
module crc5_nibble_chk
  import crc5_pkg::*;
(
  input logic clk_i,
  input logic rst_i,
  input logic init_i,
  input logic seed_ones_i,
  input logic vld_i,
  input nib_t nib_i,
  input crc_t crc_o,
  input logic upd_en,
  input logic seed_load
);
  // R1: accepted nibble equals four serial steps (checked against the unrolled form)
  p_step_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (vld_i && !init_i) |=> (crc_o == crc_nib_chain($past(crc_o), $past(nib_i))));

  // R2: seed after reset
  p_reset_seed_r2: assert property (@(posedge clk_i)
    $past(rst_i) |-> (crc_o == ($past(seed_ones_i) ? 5'b11111 : 5'b00000)));

  // R4: init wins over the strobe
  p_init_prio_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (init_i && vld_i) |=> (crc_o == ($past(seed_ones_i) ? 5'b11111 : 5'b00000)));

  // R5: no strobe, no change
  p_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!vld_i && !init_i) |=> $stable(crc_o));

  // R8: zero stays zero under a zero nibble
  p_zero_fixed_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (vld_i && !init_i && crc_o == '0 && nib_i == '0) |=> (crc_o == '0));

  // R4: load and update never both active
  p_excl_r4: assert property (@(posedge clk_i) !(upd_en && seed_load));
endmodule

bind crc5_nibble_engine crc5_nibble_chk u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .init_i      (init_i),
  .seed_ones_i (seed_ones_i),
  .vld_i       (vld_i),
  .nib_i       (nib_i),
  .crc_o       (crc_o),
  .upd_en      (upd_en),
  .seed_load   (seed_load)
);

// File: tb/tb_crc5_nibble_engine.sv
module tb_crc5_nibble_engine;
  logic       clk = 1'b0;
  logic       rst_i = 1'b1;
  logic       init_i = 1'b0;
  logic       seed_ones_i = 1'b0;
  logic       vld_i = 1'b0;
  logic [3:0] nib_i = 4'h0;
  logic [4:0] crc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  crc5_nibble_engine dut (
    .clk_i       (clk),
    .rst_i       (rst_i),
    .init_i      (init_i),
    .seed_ones_i (seed_ones_i),
    .vld_i       (vld_i),
    .nib_i       (nib_i),
    .crc_o       (crc_o)
  );

  // bench's own bit-at-a-time division model, earliest bit first
  function automatic logic [4:0] model_bits(logic [4:0] c, logic [7:0] bits, int n);
    logic [4:0] r;
    logic top;
    r = c;
    for (int k = n - 1; k >= 0; k--) begin
      top = r[4] ^ bits[k];
      r = r << 1;
      if (top) r = r ^ 5'h05;
    end
    return r;
  endfunction

  // {seed_ones, nibble, expected}
  localparam logic [9:0] VEC [0:6] = '{
    {1'b0, 4'b1010, 5'b00111},
    {1'b1, 4'b1010, 5'b00001},
    {1'b0, 4'b0000, 5'b00000},
    {1'b0, 4'b1000, 5'b01101},
    {1'b0, 4'b0001, 5'b00101},
    {1'b1, 4'b0000, 5'b00110},
    {1'b1, 4'b1111, 5'b10000}
  };

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: crc_o=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(logic r, logic i, logic s, logic v, logic [3:0] n);
    @(negedge clk);
    rst_i = r; init_i = i; seed_ones_i = s; vld_i = v; nib_i = n;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [4:0] model;
    logic [4:0] held;
    cyc(1, 0, 0, 0, 4'h0);
    cyc(1, 0, 0, 0, 4'h0);
    check("R2 reset zero seed", crc_o, 5'b00000);
    cyc(1, 0, 1, 0, 4'h0);
    check("R2 reset ones seed", crc_o, 5'b11111);

    // table of single nibbles from a seed
    foreach (VEC[i]) begin
      cyc(1, 0, VEC[i][9], 0, 4'h0);
      cyc(0, 0, VEC[i][9], 1, VEC[i][8:5]);
      check("R3 table", crc_o, VEC[i][4:0]);
      check("R1 table vs serial", crc_o,
            model_bits(VEC[i][9] ? 5'h1F : 5'h00, {4'h0, VEC[i][8:5]}, 4));
    end

    // R5: strobe low, nibble ignored
    held = crc_o;
    for (int k = 0; k < 3; k++) begin
      cyc(0, 0, 0, 0, 4'hF - 4'(k));
      check("R5 hold", crc_o, held);
    end

    // R4: init with strobe high loads seed
    cyc(0, 1, 0, 1, 4'hA);
    check("R4 init zero over vld", crc_o, 5'b00000);
    cyc(0, 0, 0, 1, 4'hC);
    cyc(0, 1, 1, 1, 4'h3);
    check("R4 init ones over vld", crc_o, 5'b11111);

    // R8: zero stays zero
    cyc(0, 1, 0, 0, 4'h0);
    cyc(0, 0, 0, 1, 4'h0);
    cyc(0, 0, 0, 1, 4'h0);
    check("R8 zero fixed point", crc_o, 5'b00000);

    // R6: two-nibble message, no flush
    cyc(0, 1, 0, 0, 4'h0);
    cyc(0, 0, 0, 1, 4'b1101);
    check("R6 first nibble", crc_o, model_bits(5'h00, 8'b0000_1101, 4));
    cyc(0, 0, 0, 1, 4'b1010);
    check("R6 eight-bit message", crc_o, model_bits(5'h00, 8'b1101_1010, 8));

    // R7/R1: back-to-back random stream with gaps and re-inits
    cyc(0, 1, 1, 0, 4'h0);
    model = 5'h1F;
    for (int k = 0; k < 300; k++) begin
      logic v, ini, so;
      logic [3:0] n;
      v   = ($urandom % 4) != 0;
      ini = ($urandom % 40) == 0;
      so  = 1'($urandom);
      n   = 4'($urandom);
      cyc(0, ini, so, v, n);
      if (ini) model = so ? 5'h1F : 5'h00;
      else if (v) model = model_bits(model, {4'h0, n}, 4);
      check("R7 R1 stream", crc_o, model);
    end

    cyc(1, 0, 0, 0, 4'h0);
    check("R2 final reset", crc_o, 5'b00000);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: crc_o=%b expected=completion", crc_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule